// File: doc/BRIEF.md
# PCM Byte-to-Channel Sample Assembler

This block sits behind a byte-wide PCM data port and turns the bytes written to it into complete multi-channel audio samples. Each sample is one, two or three bytes long and arrives most-significant byte first. The number of interleaved channels can also be set. The byte stream carries no framing of its own. Framing comes from a control level, `align_i`. Raising it and then dropping it clears any partly built sample and returns the channel rotation to channel 0. The next byte accepted after that becomes the first byte of channel 0, the left channel.

Each completed sample is presented as a left-justified 24-bit word. Unused low bytes are filled with zeros. The word comes with its channel index and a one-cycle valid strobe. Sample width and channel count are captured from the configuration inputs only while `align_i` is high. A transfer can therefore be reconfigured only at an alignment point. After reset the block accepts no byte until the first alignment pulse has been seen.

Top module: `pcm_sample_assembler`

## Requirements
- R1: After reset, `smp_valid_o`, `smp_data_o` and `smp_chan_o` are zero. Byte writes are ignored until `align_i` has been high for at least one clock and then returned low.
- R2: After an alignment pulse (`align_i` high, then low), the next accepted byte is the first byte of a channel 0 sample. Any partly assembled sample is dropped.
- R3: A byte write in a cycle where `align_i` is high is ignored. It raises no valid and does not enter any sample.
- R4: A sample is made of the active bytes-per-sample count of accepted writes, taken in order, with the first byte the most significant.
- R5: `smp_data_o` is 24 bits wide and left-justified. The first byte is at bits [23:16], the second at [15:8] and the third at [7:0]. Bytes beyond the active width read as zero.
- R6: `smp_valid_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the last byte of a sample. `smp_data_o` and `smp_chan_o` hold that sample.
- R7: The channel index starts at 0, advances by one per completed sample and wraps from (channel count − 1) back to 0.
- R8: `cfg_bps_i` and `cfg_chans_i` are sampled only on clock edges where `align_i` is high. Changing them while `align_i` is low has no effect until the next alignment pulse.
- R9: A bytes-per-sample value of 0 behaves as 1. A channel count of 0 behaves as 1, and a count above MAX_CH (8) behaves as MAX_CH.
- R10: Idle cycles between byte writes do not change framing. Only accepted writes advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| align_i | input | 1 | Alignment level; a high-then-low pulse realigns the stream |
| cfg_bps_i | input | 2 | Bytes per sample (1 to 3), captured while `align_i` is high |
| cfg_chans_i | input | 4 | Channel count (1 to 8), captured while `align_i` is high |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte written to the PCM port |
| smp_valid_o | output | 1 | One-cycle strobe for a completed sample |
| smp_data_o | output | 24 | Left-justified sample word |
| smp_chan_o | output | 3 | Channel index of the sample |

## Verification
An off-by-one byte position shows up at the very next valid strobe. The strobe appears on the wrong write, and the word shows rotated or stale bytes. A corrupted channel counter shows up in the index of the next sample and persists until the next alignment pulse. Configuration captured at the wrong moment, or a flush that does not happen, shows up in the first sample after a toggle. That is why the tests check the first sample after every alignment, and the wrap at the last channel.

// File: rtl/pcm_asm_pkg.sv
package pcm_asm_pkg;

  // Map a configuration value onto the legal range 1..hi.
  function automatic int unsigned clamp_cfg(int unsigned v, int unsigned hi);
    if (v == 0) return 1;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pcm_align_ctrl.sv
module pcm_align_ctrl #(
  parameter int MAX_BPS = 3,
  parameter int MAX_CH  = 8,
  localparam int BPS_IW = $clog2(MAX_BPS + 1),
  localparam int CN_W   = $clog2(MAX_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              align_i,
  input  logic [BPS_IW-1:0] cfg_bps_i,
  input  logic [CN_W-1:0]   cfg_chans_i,
  output logic              armed_o,
  output logic [BPS_IW-1:0] bps_o,
  output logic [CN_W-1:0]   chans_o
);

  logic              armed_q;
  logic [BPS_IW-1:0] bps_q;
  logic [CN_W-1:0]   chans_q;

  // Configuration is captured only while alignment is held high
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      bps_q   <= BPS_IW'(1);
      chans_q <= CN_W'(1);
    end else if (align_i) begin
      armed_q <= 1'b1;
      bps_q   <= BPS_IW'(pcm_asm_pkg::clamp_cfg(int'(cfg_bps_i), MAX_BPS));
      chans_q <= CN_W'(pcm_asm_pkg::clamp_cfg(int'(cfg_chans_i), MAX_CH));
    end
  end

  assign armed_o = armed_q;
  assign bps_o   = bps_q;
  assign chans_o = chans_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !align_i |=> ($stable(bps_q) && $stable(chans_q)));

  // R9
  cfg_range_chk: assert property (@(posedge clk) disable iff (rst)
    (bps_q != '0) && (int'(bps_q) <= MAX_BPS) && (chans_q != '0) && (int'(chans_q) <= MAX_CH));

endmodule

// File: rtl/pcm_byte_packer.sv
module pcm_byte_packer #(
  parameter int BYTE_W  = 8,
  parameter int MAX_BPS = 3,
  localparam int OUT_W  = BYTE_W * MAX_BPS,
  localparam int BI_W   = (MAX_BPS > 1) ? $clog2(MAX_BPS) : 1,
  localparam int BPS_IW = $clog2(MAX_BPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [BPS_IW-1:0] bps_i,
  output logic              last_o,
  output logic [OUT_W-1:0]  word_o
);

  logic [BI_W-1:0] idx_q;

  assign last_o = wr_i && (int'(idx_q) == int'(bps_i) - 1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      idx_q <= '0;
    end else if (wr_i) begin
      idx_q <= last_o ? '0 : idx_q + BI_W'(1);
    end
  end

  // One holding register per byte lane; the current byte bypasses its lane
  for (genvar k = 0; k < MAX_BPS; k++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_i && (int'(idx_q) == k)) lane_q <= data_i;
    end

    assign word_o[OUT_W-1-k*BYTE_W -: BYTE_W] =
      (int'(idx_q) > k)  ? lane_q :
      (int'(idx_q) == k) ? data_i : '0;
  end

  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(idx_q) < int'(bps_i));

  // R2
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (idx_q == '0));

endmodule

// File: rtl/pcm_chan_rotator.sv
module pcm_chan_rotator #(
  parameter int MAX_CH = 8,
  localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
  localparam int CN_W  = $clog2(MAX_CH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [CN_W-1:0] chans_i,
  output logic [CH_W-1:0] chan_o
);

  logic [CH_W-1:0] chan_q;
  logic            at_last;

  assign at_last = (int'(chan_q) == int'(chans_i) - 1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      chan_q <= '0;
    end else if (adv_i) begin
      chan_q <= at_last ? '0 : chan_q + CH_W'(1);
    end
  end

  assign chan_o = chan_q;

  // R7
  chan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !clr_i && (int'(chan_q) + 1 == int'(chans_i))) |=> (chan_q == '0));

  // R7
  chan_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(chan_q) < int'(chans_i));

endmodule

// File: rtl/pcm_sample_assembler.sv
module pcm_sample_assembler #(
  parameter int BYTE_W  = 8,
  parameter int MAX_BPS = 3,
  parameter int MAX_CH  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              align_i,
  input  logic [$clog2(MAX_BPS+1)-1:0]      cfg_bps_i,
  input  logic [$clog2(MAX_CH+1)-1:0]       cfg_chans_i,
  input  logic                              wr_en_i,
  input  logic [BYTE_W-1:0]                 wr_data_i,
  output logic                              smp_valid_o,
  output logic [BYTE_W*MAX_BPS-1:0]         smp_data_o,
  output logic [((MAX_CH>1)?$clog2(MAX_CH):1)-1:0] smp_chan_o
);

  localparam int OUT_W  = BYTE_W * MAX_BPS;
  localparam int BPS_IW = $clog2(MAX_BPS + 1);
  localparam int CN_W   = $clog2(MAX_CH + 1);
  localparam int CH_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;

  logic              armed;
  logic [BPS_IW-1:0] bps_act;
  logic [CN_W-1:0]   chans_act;
  logic              accept;
  logic              last_byte;
  logic [OUT_W-1:0]  word;
  logic [CH_W-1:0]   chan_cur;

  pcm_align_ctrl #(.MAX_BPS(MAX_BPS), .MAX_CH(MAX_CH)) u_align (
    .clk(clk), .rst(rst), .align_i(align_i),
    .cfg_bps_i(cfg_bps_i), .cfg_chans_i(cfg_chans_i),
    .armed_o(armed), .bps_o(bps_act), .chans_o(chans_act)
  );

  assign accept = wr_en_i && armed && !align_i;

  pcm_byte_packer #(.BYTE_W(BYTE_W), .MAX_BPS(MAX_BPS)) u_pack (
    .clk(clk), .rst(rst), .clr_i(align_i), .wr_i(accept),
    .data_i(wr_data_i), .bps_i(bps_act),
    .last_o(last_byte), .word_o(word)
  );

  pcm_chan_rotator #(.MAX_CH(MAX_CH)) u_rot (
    .clk(clk), .rst(rst), .clr_i(align_i), .adv_i(last_byte),
    .chans_i(chans_act), .chan_o(chan_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid_o <= 1'b0;
      smp_data_o  <= '0;
      smp_chan_o  <= '0;
    end else begin
      smp_valid_o <= last_byte;
      if (last_byte) begin
        smp_data_o <= word;
        smp_chan_o <= chan_cur;
      end
    end
  end

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    align_i |=> !smp_valid_o);

  // R1
  unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !smp_valid_o);

  // R5
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_o && ($past(bps_act) == BPS_IW'(1))) |-> ((smp_data_o << BYTE_W) == '0));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !last_byte |=> ($stable(smp_data_o) && $stable(smp_chan_o)));

endmodule

// File: tb/test_pcm_sample_assembler.sv
module test_pcm_sample_assembler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        align_i = 1'b0;
  logic [1:0]  cfg_bps_i = 2'd1;
  logic [3:0]  cfg_chans_i = 4'd2;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic        smp_valid_o;
  logic [23:0] smp_data_o;
  logic [2:0]  smp_chan_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pcm_sample_assembler i_pcm_sample_assembler (
    .clk(clk), .rst(rst), .align_i(align_i),
    .cfg_bps_i(cfg_bps_i), .cfg_chans_i(cfg_chans_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o), .smp_chan_o(smp_chan_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; one write, checked at the next falling edge
  task automatic send(logic [7:0] b, bit ev, logic [23:0] ed, int ec, string tag);
    wr_en_i   = 1'b1;
    wr_data_i = b;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk({tag, " valid"}, 32'(smp_valid_o), 32'(ev));
    if (ev) begin
      chk({tag, " data"}, 32'(smp_data_o), 32'(ed));
      chk({tag, " chan"}, 32'(smp_chan_o), 32'(ec));
    end
  endtask

  task automatic idle_chk(string tag);
    @(negedge clk);
    chk({tag, " idle valid"}, 32'(smp_valid_o), 32'd0);
  endtask

  task automatic do_align(int bps, int ch);
    align_i     = 1'b1;
    cfg_bps_i   = 2'(bps);
    cfg_chans_i = 4'(ch);
    @(negedge clk);
    align_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", 32'(smp_valid_o), 32'd0);
    chk("R1 reset data", 32'(smp_data_o), 32'd0);
    chk("R1 reset chan", 32'(smp_chan_o), 32'd0);
    send(8'hA5, 1'b0, 24'h0, 0, "R1 write before alignment");
    send(8'h5A, 1'b0, 24'h0, 0, "R1 second write before alignment");
  endtask

  task automatic t_stereo8();
    do_align(1, 2);
    send(8'h81, 1'b1, 24'h810000, 0, "R2 R5 first byte left");
    send(8'h42, 1'b1, 24'h420000, 1, "R7 second byte right");
    send(8'h13, 1'b1, 24'h130000, 0, "R7 third byte wraps left");
    send(8'hFE, 1'b1, 24'hFE0000, 1, "R6 fourth byte right");
    idle_chk("R6 single pulse");
  endtask

  task automatic t_24bit();
    do_align(3, 2);
    send(8'h11, 1'b0, 24'h0, 0, "R4 byte1");
    send(8'h22, 1'b0, 24'h0, 0, "R4 byte2");
    send(8'h33, 1'b1, 24'h112233, 0, "R4 left 24-bit");
    send(8'h44, 1'b0, 24'h0, 0, "R4 byte4");
    send(8'h55, 1'b0, 24'h0, 0, "R4 byte5");
    send(8'h66, 1'b1, 24'h445566, 1, "R4 right 24-bit");
  endtask

  task automatic t_16bit_three();
    do_align(2, 3);
    for (int s = 0; s < 6; s++) begin
      send(8'(8'hA0 + s), 1'b0, 24'h0, 0, "R4 16-bit high");
      send(8'(8'h10 + s), 1'b1, {8'(8'hA0 + s), 8'(8'h10 + s), 8'h00}, s % 3,
           "R7 R5 16-bit three channels");
    end
  endtask

  task automatic t_realign();
    do_align(3, 2);
    send(8'h01, 1'b0, 24'h0, 0, "R2 pre byte1");
    send(8'h02, 1'b0, 24'h0, 0, "R2 pre byte2");
    send(8'h03, 1'b1, 24'h010203, 0, "R2 pre sample");
    send(8'h04, 1'b0, 24'h0, 0, "R2 partial byte1");
    send(8'h05, 1'b0, 24'h0, 0, "R2 partial byte2");
    do_align(3, 2);
    chk("R2 no valid at realign", 32'(smp_valid_o), 32'd0);
    send(8'h07, 1'b0, 24'h0, 0, "R2 new byte1");
    send(8'h08, 1'b0, 24'h0, 0, "R2 new byte2");
    send(8'h09, 1'b1, 24'h070809, 0, "R2 partial dropped channel reset");
  endtask

  task automatic t_ignore_high();
    align_i     = 1'b1;
    cfg_bps_i   = 2'd3;
    cfg_chans_i = 4'd2;
    @(negedge clk);
    send(8'hEE, 1'b0, 24'h0, 0, "R3 write while high 1");
    send(8'hDD, 1'b0, 24'h0, 0, "R3 write while high 2");
    send(8'hCC, 1'b0, 24'h0, 0, "R3 write while high 3");
    align_i = 1'b0;
    send(8'h0C, 1'b0, 24'h0, 0, "R3 after release byte1");
    send(8'h0D, 1'b0, 24'h0, 0, "R3 after release byte2");
    send(8'h0E, 1'b1, 24'h0C0D0E, 0, "R3 ignored bytes kept out");
  endtask

  task automatic t_cfg_change();
    do_align(1, 2);
    cfg_bps_i   = 2'd3;
    cfg_chans_i = 4'd4;
    send(8'hA1, 1'b1, 24'hA10000, 0, "R8 width unchanged");
    send(8'hA2, 1'b1, 24'hA20000, 1, "R8 second sample");
    send(8'hA3, 1'b1, 24'hA30000, 0, "R8 count unchanged wraps at 2");
  endtask

  task automatic t_clamp();
    do_align(0, 0);
    send(8'h31, 1'b1, 24'h310000, 0, "R9 zero width as 1");
    send(8'h32, 1'b1, 24'h320000, 0, "R9 zero count as 1");
    do_align(1, 15);
    for (int s = 0; s < 9; s++)
      send(8'(8'h50 + s), 1'b1, {8'(8'h50 + s), 16'h0}, s % 8, "R9 count above max");
  endtask

  task automatic t_gaps();
    do_align(2, 2);
    send(8'h12, 1'b0, 24'h0, 0, "R10 gap byte1");
    idle_chk("R10 gap");
    idle_chk("R10 gap");
    send(8'h34, 1'b1, 24'h123400, 0, "R10 gapped sample left");
    idle_chk("R6 pulse ends");
    send(8'h56, 1'b0, 24'h0, 0, "R10 gap byte3");
    idle_chk("R10 gap");
    send(8'h78, 1'b1, 24'h567800, 1, "R10 gapped sample right");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_stereo8();
    t_24bit();
    t_16bit_three();
    t_realign();
    t_ignore_high();
    t_cfg_change();
    t_clamp();
    t_gaps();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule